// File: doc/BRIEF.md
# Saturating Round-to-Nearest Narrowing Stage

This block takes a wide signed two's-complement fixed-point word, typically the full-precision result of a multiplier, and narrows it to a smaller signed fixed-point format. The fraction bits that do not fit are rounded away. By default the result goes to the nearest representable value, and an exact halfway value goes to the neighbour whose last bit is zero. A per-sample mode bit selects a cheaper scheme instead, in which halfway values always move toward positive infinity.

When the rounded value does not fit the output format, it is clamped to the largest positive or most negative output code. It never wraps. An overflow flag marks each sample that was clamped. The wide operand is registered before the rounding and clamping logic, so the long path from the upstream multiplier is split from the carry chain of the rounding increment. A valid strobe travels with the data through both register stages.

A format written Qi.f has i integer bits, sign included, and f fraction bits. Q4.4 is therefore 8 bits wide, and its code c stands for the value c / 2^4. The input and output integer and fraction widths are parameters. The defaults take Q6.10 in and produce Q4.4 out, which discards 6 fraction bits.

Top module: `sat_round_narrow`

## Requirements
- R1: The input word is IN_INT+IN_FRAC bits and the output word is OUT_INT+OUT_FRAC bits. Both are two's complement, with the binary point OUT_FRAC (or IN_FRAC) bits above the LSB. The parameters must satisfy IN_FRAC > OUT_FRAC and IN_INT >= OUT_INT.
- R2: A sample presented with in_valid high on clock edge k appears on out_word with out_valid high just after edge k+2. out_valid is low in every cycle that does not correspond to such a sample.
- R3: A discarded part below one half of an output LSB truncates toward minus infinity. A discarded part above one half rounds up by one output LSB. This holds in both modes.
- R4: With round_mode = 0, a discarded part of exactly one half rounds to whichever neighbouring output code has bit 0 equal to 0.
- R5: With round_mode = 1, a discarded part of exactly one half always rounds up by one LSB, toward positive infinity, for both positive and negative inputs.
- R6: A rounded value above the output range yields code 0111…1. A rounded value below the range yields code 1000…0. In-range values are never altered by this step.
- R7: When the rounding increment alone carries a value past the largest code, the result is clamped and flagged, exactly as for any other overflow.
- R8: out_ovf is high exactly in the cycle in which a valid output sample was clamped. It is low for in-range samples and whenever out_valid is low, including when an out-of-range word arrives with in_valid low.
- R9: While rst_n is low, out_valid, out_ovf and out_word are all 0.
- R10: round_mode is sampled together with each valid input word. Consecutive samples may use different modes without affecting each other.
- R11: The most negative input code clamps to the most negative output code with out_ovf set. A value that rounds to exactly the most negative output code is passed without the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies in_word and round_mode |
| in_word | input | IN_INT+IN_FRAC | Wide signed fixed-point operand |
| round_mode | input | 1 | 0 = ties to even, 1 = ties toward positive infinity |
| out_valid | output | 1 | Qualifies out_word and out_ovf |
| out_word | output | OUT_INT+OUT_FRAC | Rounded and saturated result |
| out_ovf | output | 1 | Result was clamped to a format limit |

## Verification
A directed table drives exact halfway values with both odd and even kept parts, on both signs and in both modes. This is the only input pattern that tells ties-to-even apart from ties-up, and both apart from plain truncation. Values slightly above and below one half confirm that the mode has no effect outside ties. Range-edge words check the boundaries: the largest and smallest exactly representable codes, a half that carries past the largest code, a half just below the most negative code that rounds into range, and the most negative input. Together they separate a correct clamp from an off-by-one limit or a wrap. A long random stream of mixed valid gaps, modes and edge-biased words is then compared cycle by cycle against an exact integer remainder model. This checks the two-cycle alignment of data, flag and strobe while the mode changes from sample to sample.

// File: rtl/snr_pkg.sv
`timescale 1ns/1ps
package snr_pkg;
   typedef enum logic {
      RND_TIES_EVEN = 1'b0,
      RND_TIES_UP   = 1'b1
   } rnd_mode_e;
endpackage

// File: rtl/snr_capture.sv
`timescale 1ns/1ps
// First pipeline stage: holds the unrounded wide operand and its mode so the
// rounding carry chain starts from a register rather than from upstream logic.
module snr_capture
   import snr_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            valid_i,
   input  rnd_mode_e       mode_i,
   input  logic [W-1:0]    word_i,
   output logic            valid_q,
   output rnd_mode_e       mode_q,
   output logic [W-1:0]    word_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         mode_q  <= RND_TIES_EVEN;
         word_q  <= '0;
      end else begin
         valid_q <= valid_i;
         if (valid_i) begin
            mode_q <= mode_i;
            word_q <= word_i;
         end
      end
   end

   // R10: a held word changes only when a new valid sample arrives
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> $stable(word_q));
endmodule

// File: rtl/snr_decide.sv
`timescale 1ns/1ps
// Combinational rounding: split off the discarded bits, form guard/sticky,
// decide the increment per mode and add it to the kept part (one extra bit).
module snr_decide
   import snr_pkg::*;
#(
   parameter int unsigned IN_W = 16,
   parameter int unsigned DROP = 6,
   localparam int unsigned KW  = IN_W - DROP,
   localparam int unsigned SW  = KW + 1
) (
   input  logic [IN_W-1:0] word_i,
   input  rnd_mode_e       mode_i,
   output logic [SW-1:0]   sum_o
);
   logic [KW-1:0] kept;
   logic          guard;
   logic          sticky;
   logic          inc;

   assign kept  = word_i[IN_W-1:DROP];
   assign guard = word_i[DROP-1];

   generate
      if (DROP == 1) begin : g_no_sticky
         assign sticky = 1'b0;
      end else begin : g_sticky
         assign sticky = |word_i[DROP-2:0];
      end
   endgenerate

   always_comb begin
      unique case (mode_i)
         RND_TIES_UP:   inc = guard;
         default:       inc = guard & (sticky | kept[0]);
      endcase
   end

   assign sum_o = {kept[KW-1], kept} + {{KW{1'b0}}, inc};

   // R3: without the half bit nothing is ever added to the kept part
   always_comb begin
      if (!guard) begin
         p_guard_gate_r3: assert (sum_o == {kept[KW-1], kept});
      end
   end
endmodule

// File: rtl/snr_clamp.sv
`timescale 1ns/1ps
// Second pipeline stage: range check of the rounded sum, clamp to the output
// limits, register word, strobe and overflow flag together.
module snr_clamp #(
   parameter int unsigned SW    = 11,
   parameter int unsigned OUT_W = 8,
   localparam int unsigned HW   = SW - OUT_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid_i,
   input  logic [SW-1:0]    sum_i,
   output logic             valid_o,
   output logic [OUT_W-1:0] word_o,
   output logic             ovf_o
);
   localparam logic [OUT_W-1:0] MAX_CODE = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic [OUT_W-1:0] MIN_CODE = {1'b1, {(OUT_W-1){1'b0}}};

   logic [HW-1:0]    head;
   logic             fits;
   logic [OUT_W-1:0] clamped;

   assign head = sum_i[SW-1:OUT_W-1];
   assign fits = (&head) | ~(|head);

   always_comb begin
      if (fits)               clamped = sum_i[OUT_W-1:0];
      else if (sum_i[SW-1])   clamped = MIN_CODE;
      else                    clamped = MAX_CODE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         word_o  <= '0;
         ovf_o   <= 1'b0;
      end else begin
         valid_o <= valid_i;
         word_o  <= clamped;
         ovf_o   <= valid_i & ~fits;
      end
   end

   // R8: the flag only ever accompanies a valid sample
   p_ovf_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> valid_o);
   // R6: a flagged word is one of the two format limits
   p_ovf_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> (word_o == MAX_CODE || word_o == MIN_CODE));
   // R7: a flagged word keeps the sign of the rounded sum
   p_ovf_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i && !fits |=> word_o[OUT_W-1] == $past(sum_i[SW-1]));
endmodule

// File: rtl/sat_round_narrow.sv
`timescale 1ns/1ps
module sat_round_narrow
   import snr_pkg::*;
#(
   parameter int unsigned IN_INT   = 6,
   parameter int unsigned IN_FRAC  = 10,
   parameter int unsigned OUT_INT  = 4,
   parameter int unsigned OUT_FRAC = 4,
   localparam int unsigned IN_W    = IN_INT + IN_FRAC,
   localparam int unsigned OUT_W   = OUT_INT + OUT_FRAC
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [IN_W-1:0]  in_word,
   input  logic             round_mode,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_word,
   output logic             out_ovf
);
   localparam int unsigned DROP = IN_FRAC - OUT_FRAC;
   localparam int unsigned SW   = IN_W - DROP + 1;

   // R1: format constraints checked once at start
   initial begin
      p_frac_order_r1: assert (IN_FRAC > OUT_FRAC)
         else $error("fraction bits must shrink");
      p_int_order_r1: assert (IN_INT >= OUT_INT)
         else $error("integer bits must not grow");
      p_out_width_r1: assert (OUT_W >= 2)
         else $error("output needs sign and magnitude");
   end

   logic            v_q;
   rnd_mode_e       m_q;
   logic [IN_W-1:0] w_q;
   logic [SW-1:0]   sum;

   snr_capture #(.W(IN_W)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (in_valid),
      .mode_i  (rnd_mode_e'(round_mode)),
      .word_i  (in_word),
      .valid_q (v_q),
      .mode_q  (m_q),
      .word_q  (w_q)
   );

   snr_decide #(.IN_W(IN_W), .DROP(DROP)) u_dec (
      .word_i (w_q),
      .mode_i (m_q),
      .sum_o  (sum)
   );

   snr_clamp #(.SW(SW), .OUT_W(OUT_W)) u_clp (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (v_q),
      .sum_i   (sum),
      .valid_o (out_valid),
      .word_o  (out_word),
      .ovf_o   (out_ovf)
   );

   // cycles since reset, so the latency check never looks before reset
   logic [1:0] warm;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          warm <= 2'd0;
      else if (warm != 3)  warm <= warm + 2'd1;
   end

   // R2: strobe comes out exactly two clocks after it went in
   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2'd3) |-> out_valid == $past(in_valid, 2));
endmodule

// File: tb/sim_sat_round_narrow.sv
`timescale 1ns/1ps
module sim_sat_round_narrow;
   localparam int NV = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_word = '0;
   logic        round_mode = 1'b0;
   logic        out_valid;
   logic [7:0]  out_word;
   logic        out_ovf;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   sat_round_narrow u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
      .round_mode(round_mode), .out_valid(out_valid), .out_word(out_word),
      .out_ovf(out_ovf)
   );

   // Q6.10 in, Q4.4 out: output code = input code / 64, rounded
   localparam logic [15:0] T_IN [NV] = '{
      16'h0000, 16'h0040, 16'h0060, 16'h0060, 16'h00A0, 16'h00A0,
      16'h0061, 16'h005F, 16'hFFA0, 16'hFFA0, 16'hFF60, 16'hFF60,
      16'hFFDF, 16'h7FFF, 16'h1FC0, 16'h1FE0, 16'h1FE0, 16'h1FA0,
      16'h1FA0, 16'h8000, 16'hE000, 16'hDFE0, 16'hDFE0, 16'hDFC0};
   localparam logic T_MODE [NV] = '{
      1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1,
      1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1,
      1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0,
      1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
   localparam logic [7:0] T_EXP [NV] = '{
      8'h00, 8'h01, 8'h02, 8'h02, 8'h02, 8'h03,
      8'h02, 8'h01, 8'hFE, 8'hFF, 8'hFE, 8'hFE,
      8'hFF, 8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'h7E,
      8'h7F, 8'h80, 8'h80, 8'h80, 8'h80, 8'h80};
   localparam logic T_OVF [NV] = '{
      1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
      1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
      1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0,
      1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};

   function automatic string tag_of(input int i);
      case (i)
         0, 1, 6, 7, 12:           return "R3";
         2, 4, 8, 10, 17:          return "R4";
         3, 5, 9, 11, 18:          return "R5";
         13, 14:                   return "R6";
         15, 16:                   return "R7";
         default:                  return "R11";
      endcase
   endfunction

   // exact integer model: floor quotient, remainder compared with one half
   function automatic logic [8:0] model(input logic [15:0] x, input logic m);
      int v, q, r;
      bit up;
      v  = int'($signed(x));
      q  = v >>> 6;
      r  = v - q * 64;
      up = (r > 32) || (r == 32 && (m || (q % 2 != 0)));
      q  = q + (up ? 1 : 0);
      if (q > 127)       return {1'b1, 8'h7F};
      else if (q < -128) return {1'b1, 8'h80};
      else               return {1'b0, q[7:0]};
   endfunction

   task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got valid/ovf/word=%b/%b/%h expected %b/%b/%h",
                  tag, act[9], act[8], act[7:0], exp[9], exp[8], exp[7:0]);
      end
   endtask

   task automatic run_one(input logic [15:0] w, input logic m,
                          input logic [7:0] e, input logic eo, input string tag);
      @(negedge clk);
      in_word = w; round_mode = m; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0; in_word = 16'h0000; round_mode = ~m;
      @(negedge clk);
      check(tag, {out_valid, out_ovf, out_word}, {1'b1, eo, e});
      @(negedge clk);
      check("R2", {out_valid, out_ovf, 8'h00}, 10'h000);
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [8:0] pe [2];
      logic       pv [2];
      repeat (3) @(negedge clk);
      // R9: reset state
      check("R9", {out_valid, out_ovf, out_word}, 10'h000);
      in_valid = 1'b1; in_word = 16'h7FFF;
      @(negedge clk);
      check("R9", {out_valid, out_ovf, out_word}, 10'h000);
      in_valid = 1'b0;
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1 R3..R7 R11: directed table
      for (int i = 0; i < NV; i++) begin
         run_one(T_IN[i], T_MODE[i], T_EXP[i], T_OVF[i], tag_of(i));
      end

      // R8: out-of-range words without in_valid raise nothing
      @(negedge clk);
      in_valid = 1'b0; in_word = 16'h7FFF;
      @(negedge clk);
      in_word = 16'h8000;
      @(negedge clk);
      check("R8", {out_valid, out_ovf, 8'h00}, 10'h000);
      @(negedge clk);
      check("R8", {out_valid, out_ovf, 8'h00}, 10'h000);
      // held word from the last valid sample (0xDFC0) still the clamp value
      check("R8", {2'b00, out_word}, {2'b00, 8'h80});

      // R1: a mid-range value lands on the expected Q4.4 code (3.25 -> 0x34)
      run_one(16'h0D00, 1'b0, 8'h34, 1'b0, "R1");

      // R10 R2: back-to-back random stream with alternating modes
      pv[0] = 1'b0; pv[1] = 1'b0; pe[0] = '0; pe[1] = '0;
      for (int n = 0; n < 2000; n++) begin
         logic [15:0] w;
         logic        m, v;
         @(negedge clk);
         if (pv[1]) check("R10", {out_valid, out_ovf, out_word}, {1'b1, pe[1]});
         else       check("R2",  {out_valid, out_ovf, 8'h00}, 10'h000);
         pv[1] = pv[0]; pe[1] = pe[0];
         case ($urandom_range(0, 4))
            0:       w = {$urandom_range(0, 1023), 6'b100000};
            1:       w = 16'h1FC0 + 16'($urandom_range(0, 63));
            2:       w = 16'hDFC0 + 16'($urandom_range(0, 127));
            default: w = 16'($urandom);
         endcase
         m = n[0] ^ 1'($urandom_range(0, 1) & (n % 3 == 0));
         v = ($urandom_range(0, 3) != 0);
         in_word = w; round_mode = m; in_valid = v;
         pv[0] = v; pe[0] = model(w, m);
      end
      @(negedge clk);
      in_valid = 1'b0;
      if (pv[1]) check("R10", {out_valid, out_ovf, out_word}, {1'b1, pe[1]});
      @(negedge clk);
      if (pv[0]) check("R10", {out_valid, out_ovf, out_word}, {1'b1, pe[0]});

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule